// File: doc/BRIEF.md
# Store Queue with In-Order Memory Writeback

This block holds the store instructions of an out-of-order core from dispatch until memory has acknowledged them. Stores enter at the tail in program order. A commit sequence number, or a successful execution in the case of a store-conditional, makes an entry eligible to leave. A writeback pointer then walks the eligible entries in order and presents one memory request per cycle. Memory may acknowledge these requests in any order. The head only moves past a run of acknowledged entries, so slots are freed strictly in order.

There are three exceptional paths. Zero-byte stores, and store-conditionals whose reservation was lost, finish without any memory traffic; a lost store-conditional also raises a delayed failure notice. When memory refuses a request, the queue blocks and keeps the request. It presents the request again only after a retry pulse. A squash trims speculative stores from the tail but never removes a store that has already been released for writeback.

Top module: `store_wb_queue`

## Requirements
- R1: The queue holds `DEPTH` stores in a ring of `DEPTH+1` slots. `free_slots` reports `DEPTH` minus occupancy. `alloc_ready` is low exactly when the queue is full. An allocation attempted while full is ignored: the tail index and the free count do not change. An allocation in a cycle with `squash_valid` high is also ignored. Slots are handed out as consecutive indices modulo `DEPTH+1`, starting at 0.
- R2: A commit walks from the oldest entry toward the youngest. It releases every entry not yet released whose sequence number is at most `commit_seq`. It stops at the first unreleased entry with a larger number. Entries beyond that point stay unreleased even if their numbers are small enough.
- R3: An execute pulse on `sc_exec_idx` releases that entry without any commit.
- R4: Requests leave strictly in slot order, at most one per cycle. The writeback pointer stops at the first unreleased entry, and nothing is sent for an unreleased entry.
- R5: A released entry of size 0 completes without any memory request.
- R6: `req_kind` uses the same encoding as `alloc_kind`: 0 for a plain write, 1 for a swap, 2 for a store-conditional. `req_idx`, `req_size` and `req_data` are the slot index, size and data of the entry being written back.
- R7: When the writeback pointer reaches a store-conditional while `sc_link_ok` is low, the entry completes without a request. `scfail_valid` pulses one cycle after that completion, carrying the slot in `scfail_idx`.
- R8: A request presented while `req_ready` is low is withdrawn in the next cycle, and the queue becomes blocked. While blocked, no request is presented until a `mem_retry` pulse, which re-presents the held request in the following cycle. The blocked state ends only when a presented request meets `req_ready` high. After that, later stores flow again.
- R9: A refused request is re-presented with the identical index, kind, size and data.
- R10: `ack_valid` with `ack_idx` marks a sent entry complete. An acknowledgement for a slot whose request was never sent is ignored. Free space grows only when the oldest entry completes, and then by the length of the run of consecutive completed entries starting at the oldest.
- R11: A squash removes entries from the youngest end whose sequence number exceeds `squash_seq`. It stops at the first entry that is already released or not younger. The tail moves back to the first removed slot, and the free count rises accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_kind | input | 2 | 0 write, 1 swap, 2 store-conditional |
| alloc_size | input | SIZE_W | Byte count, 0 means no memory access |
| alloc_data | input | DATA_W | Store data |
| alloc_ready | output | 1 | Queue not full |
| alloc_idx | output | IW | Slot the next allocation takes |
| free_slots | output | IW | Number of free entries |
| sc_exec_valid | input | 1 | Store-conditional executed without fault |
| sc_exec_idx | input | IW | Slot of that store-conditional |
| sc_link_ok | input | 1 | Reservation still held at writeback |
| commit_valid | input | 1 | Commit pulse |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Stores younger than this are discarded |
| req_valid | output | 1 | Memory write request present |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_idx | output | IW | Slot of the request |
| req_kind | output | 2 | Request kind, same encoding as alloc_kind |
| req_size | output | SIZE_W | Request byte count |
| req_data | output | DATA_W | Request data |
| mem_retry | input | 1 | Memory can take the refused request now |
| ack_valid | input | 1 | Memory acknowledges a write |
| ack_idx | input | IW | Slot being acknowledged |
| scfail_valid | output | 1 | Store-conditional failure notice |
| scfail_idx | output | IW | Slot of the failed store-conditional |

## Verification
A stray release flag shows up within two cycles as a request on the memory port for a store that was never committed or executed. A missing flag shows up as a stall in the request stream. A damaged completion bit or head pointer shows in `free_slots`: the count either jumps over a gap in the acknowledgements or stays low after the oldest entry is acknowledged, one cycle after the acknowledgement. A squash that walks too far or not far enough is visible at once in `alloc_idx` and `free_slots`. A wrong blocked state surfaces as a request appearing without a retry, or as a request that never returns after one.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SK_WRITE = 2'd0,
    SK_SWAP  = 2'd1,
    SK_COND  = 2'd2
  } st_kind_e;

  // modular ring step: (a + k) mod n, all operands non-negative
  function automatic int ring_add(int a, int k, int n);
    return (a + k) % n;
  endfunction
endpackage

// File: rtl/sq_payload_ram.sv
module sq_payload_ram #(
  parameter int SLOTS = 5,
  parameter int IW    = 3,
  parameter int W     = 38
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sq_commit_scan.sv
module sq_commit_scan import sq_pkg::*; #(
  parameter int SLOTS = 5,
  parameter int IW    = 3,
  parameter int SEQ_W = 16
) (
  input  logic [IW-1:0]                 head_i,
  input  logic [IW-1:0]                 occ_i,
  input  logic [SLOTS-1:0]              canwb_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0]   seq_i,
  input  logic [SEQ_W-1:0]              commit_seq_i,
  output logic [SLOTS-1:0]              mark_o
);
  logic          go;
  logic [IW-1:0] idx;

  always_comb begin
    mark_o = '0;
    go     = 1'b1;
    idx    = '0;
    for (int k = 0; k < SLOTS; k++) begin
      idx = IW'(ring_add(int'(head_i), k, SLOTS));
      if (go && k < int'(occ_i) && !canwb_i[idx]) begin
        if (seq_i[idx] <= commit_seq_i) mark_o[idx] = 1'b1;
        else                            go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan import sq_pkg::*; #(
  parameter int SLOTS = 5,
  parameter int IW    = 3,
  parameter int SEQ_W = 16
) (
  input  logic [IW-1:0]               tail_i,
  input  logic [IW-1:0]               occ_i,
  input  logic [SLOTS-1:0]            canwb_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0]            squash_seq_i,
  output logic [IW-1:0]               tail_o
);
  logic          go;
  logic [IW-1:0] idx;
  int            rm;

  always_comb begin
    go  = 1'b1;
    rm  = 0;
    idx = '0;
    for (int k = 1; k < SLOTS; k++) begin
      idx = IW'(ring_add(int'(tail_i), SLOTS - k, SLOTS));
      if (go && k <= int'(occ_i)) begin
        if (canwb_i[idx] || seq_i[idx] <= squash_seq_i) go = 1'b0;
        else                                            rm = rm + 1;
      end
    end
    tail_o = IW'(ring_add(int'(tail_i), SLOTS - rm, SLOTS));
  end
endmodule

// File: rtl/sq_head_collapse.sv
module sq_head_collapse import sq_pkg::*; #(
  parameter int SLOTS = 5,
  parameter int IW    = 3
) (
  input  logic [IW-1:0]    head_i,
  input  logic [IW-1:0]    occ_i,
  input  logic [SLOTS-1:0] done_i,
  output logic [IW-1:0]    head_o
);
  logic          go;
  logic [IW-1:0] idx;
  int            adv;

  always_comb begin
    go  = 1'b1;
    adv = 0;
    idx = '0;
    for (int k = 0; k < SLOTS; k++) begin
      idx = IW'(ring_add(int'(head_i), k, SLOTS));
      if (go && k < int'(occ_i) && done_i[idx]) adv = adv + 1;
      else                                      go  = 1'b0;
    end
    head_o = IW'(ring_add(int'(head_i), adv, SLOTS));
  end
endmodule

// File: rtl/store_wb_queue.sv
module store_wb_queue import sq_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 16,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 32,
  localparam int SLOTS = DEPTH + 1,
  localparam int IW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [1:0]        alloc_kind,
  input  logic [SIZE_W-1:0] alloc_size,
  input  logic [DATA_W-1:0] alloc_data,
  output logic              alloc_ready,
  output logic [IW-1:0]     alloc_idx,
  output logic [IW-1:0]     free_slots,
  input  logic              sc_exec_valid,
  input  logic [IW-1:0]     sc_exec_idx,
  input  logic              sc_link_ok,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IW-1:0]     req_idx,
  output logic [1:0]        req_kind,
  output logic [SIZE_W-1:0] req_size,
  output logic [DATA_W-1:0] req_data,
  input  logic              mem_retry,
  input  logic              ack_valid,
  input  logic [IW-1:0]     ack_idx,
  output logic              scfail_valid,
  output logic [IW-1:0]     scfail_idx
);
  localparam int PW = DATA_W + SIZE_W + 2;

  logic [IW-1:0] head_q, wb_q, tail_q, occ, head_nx, tail_sq, wb_inc, tail_inc;
  logic [SLOTS-1:0] canwb_q, sent_q, done_q, done_nx, done_set, mark, exec_set;
  logic [SLOTS-1:0][SEQ_W-1:0] seq_q;
  logic [PW-1:0] rd_w;
  st_kind_e      rd_kind;
  logic [SIZE_W-1:0] rd_size;
  logic [DATA_W-1:0] rd_data;
  logic full, alloc_fire, slot_free, wb_go, wb_zero, wb_scfail, wb_issue, wb_skip;
  logic blocked_q, note_q;
  logic [IW-1:0] note_idx_q;

  assign occ         = IW'(ring_add(int'(tail_q), SLOTS - int'(head_q), SLOTS));
  assign full        = (int'(occ) == DEPTH);
  assign alloc_ready = !full;
  assign alloc_idx   = tail_q;
  assign free_slots  = IW'(DEPTH - int'(occ));
  assign alloc_fire  = alloc_valid && !full && !squash_valid;
  assign wb_inc      = IW'(ring_add(int'(wb_q), 1, SLOTS));
  assign tail_inc    = IW'(ring_add(int'(tail_q), 1, SLOTS));

  sq_payload_ram #(.SLOTS(SLOTS), .IW(IW), .W(PW)) u_ram (
    .clk   (clk),
    .we    (alloc_fire),
    .waddr (tail_q),
    .wdata ({alloc_data, alloc_size, alloc_kind}),
    .raddr (wb_q),
    .rdata (rd_w)
  );

  assign rd_kind = st_kind_e'(rd_w[1:0]);
  assign rd_size = rd_w[SIZE_W+1:2];
  assign rd_data = rd_w[PW-1:SIZE_W+2];

  // writeback step: one entry per cycle, only when the request register frees up
  assign slot_free = !blocked_q && (!req_valid || req_ready);
  assign wb_go     = (wb_q != tail_q) && canwb_q[wb_q] && slot_free;
  assign wb_zero   = (rd_size == '0);
  assign wb_scfail = (rd_kind == SK_COND) && !sc_link_ok;
  assign wb_skip   = wb_go && (wb_zero || wb_scfail);
  assign wb_issue  = wb_go && !wb_zero && !wb_scfail;

  always_comb begin
    done_set = '0;
    exec_set = '0;
    if (ack_valid && int'(ack_idx) < SLOTS && sent_q[ack_idx]) done_set[ack_idx] = 1'b1;
    if (wb_skip) done_set[wb_q] = 1'b1;
    if (sc_exec_valid && int'(sc_exec_idx) < SLOTS) exec_set[sc_exec_idx] = 1'b1;
    done_nx = done_q | done_set;
  end

  sq_commit_scan #(.SLOTS(SLOTS), .IW(IW), .SEQ_W(SEQ_W)) u_commit (
    .head_i(head_q), .occ_i(occ), .canwb_i(canwb_q), .seq_i(seq_q),
    .commit_seq_i(commit_seq), .mark_o(mark)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .IW(IW), .SEQ_W(SEQ_W)) u_squash (
    .tail_i(tail_q), .occ_i(occ), .canwb_i(canwb_q), .seq_i(seq_q),
    .squash_seq_i(squash_seq), .tail_o(tail_sq)
  );

  sq_head_collapse #(.SLOTS(SLOTS), .IW(IW)) u_head (
    .head_i(head_q), .occ_i(occ), .done_i(done_nx), .head_o(head_nx)
  );

  always_ff @(posedge clk) begin
    if (alloc_fire) seq_q[tail_q] <= alloc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      canwb_q <= '0;
      sent_q  <= '0;
      done_q  <= '0;
    end else begin
      done_q  <= done_nx;
      canwb_q <= canwb_q | (commit_valid ? mark : '0) | exec_set;
      if (wb_issue) sent_q[wb_q] <= 1'b1;
      if (alloc_fire) begin
        canwb_q[tail_q] <= 1'b0;
        sent_q[tail_q]  <= 1'b0;
        done_q[tail_q]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      wb_q   <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nx;
      if (wb_go) wb_q <= wb_inc;
      if (squash_valid)    tail_q <= tail_sq;
      else if (alloc_fire) tail_q <= tail_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      blocked_q <= 1'b0;
      req_idx   <= '0;
      req_kind  <= '0;
      req_size  <= '0;
      req_data  <= '0;
    end else begin
      if (req_valid) begin
        req_valid <= 1'b0;
        blocked_q <= !req_ready;
      end else if (blocked_q && mem_retry) begin
        req_valid <= 1'b1;
      end
      if (wb_issue) begin
        req_valid <= 1'b1;
        req_idx   <= wb_q;
        req_kind  <= rd_kind;
        req_size  <= rd_size;
        req_data  <= rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      note_q       <= 1'b0;
      note_idx_q   <= '0;
      scfail_valid <= 1'b0;
      scfail_idx   <= '0;
    end else begin
      note_q       <= wb_go && wb_scfail;
      note_idx_q   <= wb_q;
      scfail_valid <= note_q;
      scfail_idx   <= note_idx_q;
    end
  end
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 16,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [IW-1:0]     free_slots,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IW-1:0]     req_idx,
  input logic [1:0]        req_kind,
  input logic [SIZE_W-1:0] req_size,
  input logic [DATA_W-1:0] req_data,
  input logic              mem_retry,
  input logic              blocked_q
);
  p_free_bound_r1: assert property (@(posedge clk) disable iff (rst)
    int'(free_slots) <= DEPTH);

  p_one_alloc_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(free_slots) + 1 >= int'($past(free_slots))));

  p_no_zero_req_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_size != '0);

  p_refuse_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !req_valid);

  p_blocked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (blocked_q && !req_valid && !mem_retry) |=> !req_valid);

  p_hold_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> ($stable(req_idx) && $stable(req_kind) &&
                                   $stable(req_size) && $stable(req_data)));
endmodule

bind store_wb_queue sq_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)
) u_sq_chk (.*);

// File: tb/test_store_wb_queue.sv
`timescale 1ns/1ps
module test_store_wb_queue;
  localparam int DEPTH = 4;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0; logic [15:0] alloc_seq = 0; logic [1:0] alloc_kind = 0;
  logic [3:0] alloc_size = 0; logic [31:0] alloc_data = 0;
  logic alloc_ready; logic [IW-1:0] alloc_idx, free_slots;
  logic sc_exec_valid = 0; logic [IW-1:0] sc_exec_idx = 0; logic sc_link_ok = 1;
  logic commit_valid = 0; logic [15:0] commit_seq = 0;
  logic squash_valid = 0; logic [15:0] squash_seq = 0;
  logic req_valid; logic req_ready = 1; logic [IW-1:0] req_idx; logic [1:0] req_kind;
  logic [3:0] req_size; logic [31:0] req_data;
  logic mem_retry = 0; logic ack_valid = 0; logic [IW-1:0] ack_idx = 0;
  logic scfail_valid; logic [IW-1:0] scfail_idx;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  store_wb_queue #(.DEPTH(DEPTH), .SEQ_W(16), .SIZE_W(4), .DATA_W(32)) i_store_wb_queue (
    .clk, .rst, .alloc_valid, .alloc_seq, .alloc_kind, .alloc_size, .alloc_data,
    .alloc_ready, .alloc_idx, .free_slots, .sc_exec_valid, .sc_exec_idx, .sc_link_ok,
    .commit_valid, .commit_seq, .squash_valid, .squash_seq, .req_valid, .req_ready,
    .req_idx, .req_kind, .req_size, .req_data, .mem_retry, .ack_valid, .ack_idx,
    .scfail_valid, .scfail_idx
  );

  function automatic int dval(int s);
    return 32'hA500_0000 + s * 3;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_alloc(int s, int kind, int size);
    alloc_valid = 1; alloc_seq = 16'(s); alloc_kind = 2'(kind);
    alloc_size = 4'(size); alloc_data = 32'(dval(s));
    tick();
    alloc_valid = 0;
  endtask

  task automatic do_commit(int s);
    commit_valid = 1; commit_seq = 16'(s); tick(); commit_valid = 0;
  endtask

  task automatic do_squash(int s);
    squash_valid = 1; squash_seq = 16'(s); tick(); squash_valid = 0;
  endtask

  task automatic do_ack(int i);
    ack_valid = 1; ack_idx = IW'(i); tick(); ack_valid = 0;
  endtask

  task automatic do_exec(int i);
    sc_exec_valid = 1; sc_exec_idx = IW'(i); tick(); sc_exec_valid = 0;
  endtask

  // wait for a request (accepted when req_ready is high) and compare it
  task automatic expect_req(string tag, int eidx, int ekind, int esize, int eseq);
    bit got = 0;
    int ridx = 0, rkind = 0, rsize = 0, rdata = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      if (req_valid) begin
        got = 1; ridx = int'(req_idx); rkind = int'(req_kind);
        rsize = int'(req_size); rdata = int'(req_data);
      end
      tick();
    end
    chk({tag, " request seen"}, int'(got), 1);
    chk({tag, " idx"}, ridx, eidx);
    chk({tag, " kind R6"}, rkind, ekind);
    chk({tag, " size"}, rsize, esize);
    chk({tag, " data"}, rdata, dval(eseq));
  endtask

  task automatic expect_quiet(string tag, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (req_valid) seen++;
      tick();
    end
    chk(tag, seen, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cidx = 0, ck = 0, cs = 0, cd = 0;
    int seen = 0;
    repeat (3) tick();
    rst = 0;
    tick();
    // reset state
    chk("R1 reset free", int'(free_slots), DEPTH);
    chk("R1 reset ready", int'(alloc_ready), 1);
    chk("R1 reset idx", int'(alloc_idx), 0);
    chk("R4 reset no req", int'(req_valid), 0);
    chk("R7 reset no fail", int'(scfail_valid), 0);

    // fill: seq 10..13 in slots 0..3
    do_alloc(10, 0, 4); do_alloc(11, 1, 4); do_alloc(12, 0, 4);
    chk("R1 free after three", int'(free_slots), 1);
    do_alloc(13, 0, 4);
    chk("R1 full free", int'(free_slots), 0);
    chk("R1 full ready", int'(alloc_ready), 0);
    chk("R1 tail idx", int'(alloc_idx), 4);
    do_alloc(99, 0, 4);
    chk("R1 ignored alloc idx", int'(alloc_idx), 4);
    chk("R1 ignored alloc free", int'(free_slots), 0);
    expect_quiet("R4 nothing released", 6);

    do_ack(2); // slot 2 never sent: must be ignored (R10)
    do_commit(11);
    expect_req("R2 first", 0, 0, 4, 10);
    expect_req("R4 second", 1, 1, 4, 11);
    expect_quiet("R2 stop at younger", 5);

    do_ack(1);
    chk("R10 out of order ack keeps free", int'(free_slots), 0);
    do_ack(0);
    chk("R10 collapse two and unsent ack ignored", int'(free_slots), 2);

    do_commit(13);
    expect_req("R4 third", 2, 0, 4, 12);
    expect_req("R4 fourth", 3, 0, 4, 13);
    do_ack(3);
    chk("R10 gap at head", int'(free_slots), 2);
    do_ack(2);
    chk("R10 drained", int'(free_slots), 4);

    // zero size store in slot 4
    do_alloc(20, 0, 0);
    chk("R1 wrap idx", int'(alloc_idx), 0);
    do_commit(20);
    expect_quiet("R5 zero size no request", 6);
    chk("R5 zero size completed", int'(free_slots), 4);

    // store-conditional released by execution (slot 0), plain store slot 1
    sc_link_ok = 1;
    do_alloc(30, 2, 2); do_alloc(31, 0, 4);
    do_exec(0);
    expect_req("R3 executed sc", 0, 2, 2, 30);
    expect_quiet("R3 plain store waits", 4);
    do_commit(31);
    expect_req("R2 after sc", 1, 0, 4, 31);
    do_ack(0); do_ack(1);
    chk("R10 drained again", int'(free_slots), 4);

    // failed store-conditional in slot 2
    sc_link_ok = 0;
    do_alloc(40, 2, 4);
    do_exec(2);
    seen = 0;
    for (int i = 0; i < 10 && int'(free_slots) != 4; i++) begin
      if (req_valid) seen++;
      tick();
    end
    chk("R7 no request", seen + int'(req_valid), 0);
    chk("R7 completed", int'(free_slots), 4);
    chk("R7 notice not yet", int'(scfail_valid), 0);
    tick();
    chk("R7 notice one cycle later", int'(scfail_valid), 1);
    chk("R7 notice idx", int'(scfail_idx), 2);
    tick();
    chk("R7 notice is a pulse", int'(scfail_valid), 0);
    sc_link_ok = 1;

    // refusal and retry: slot 3 seq 50, slot 4 seq 51
    req_ready = 0;
    do_alloc(50, 1, 3);
    do_commit(50);
    seen = 0;
    for (int i = 0; i < 10 && !req_valid; i++) tick();
    chk("R8 presented", int'(req_valid), 1);
    cidx = int'(req_idx); ck = int'(req_kind); cs = int'(req_size); cd = int'(req_data);
    tick();
    chk("R8 withdrawn after refusal", int'(req_valid), 0);
    do_alloc(51, 0, 4);
    do_commit(51);
    expect_quiet("R8 blocked without retry", 5);
    mem_retry = 1; tick(); mem_retry = 0;
    chk("R8 retry re-presents", int'(req_valid), 1);
    chk("R9 same idx", int'(req_idx), cidx);
    chk("R9 same kind", int'(req_kind), ck);
    chk("R9 same size", int'(req_size), cs);
    chk("R9 same data", int'(req_data), cd);
    tick();
    chk("R8 refused again", int'(req_valid), 0);
    expect_quiet("R8 still blocked", 3);
    req_ready = 1;
    mem_retry = 1; tick(); mem_retry = 0;
    expect_req("R9 accepted resend", 3, 1, 3, 50);
    expect_req("R8 unblocked next store", 4, 0, 4, 51);
    do_ack(3); do_ack(4);
    chk("R10 drained after retry", int'(free_slots), 4);

    // squash: slots 0..3 seq 60..63, 60 released
    do_alloc(60, 0, 4); do_alloc(61, 0, 4); do_alloc(62, 0, 4); do_alloc(63, 0, 4);
    do_commit(60);
    expect_req("R11 released kept", 0, 0, 4, 60);
    do_squash(60);
    chk("R11 squash free", int'(free_slots), 3);
    chk("R11 squash tail", int'(alloc_idx), 1);
    expect_quiet("R11 squashed not sent", 3);
    do_alloc(71, 2, 4); do_alloc(72, 0, 4);
    do_exec(1);
    expect_req("R3 sc after squash", 1, 2, 4, 71);
    do_squash(70);
    chk("R11 stop at released free", int'(free_slots), 2);
    chk("R11 stop at released tail", int'(alloc_idx), 2);
    do_ack(0); do_ack(1);
    chk("R10 final drain", int'(free_slots), 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule